// File: doc/BRIEF.md
# Dual-mode SPI byte port

This block is a byte-wide serial port that works as either master or slave of an SPI link. The CPU side sees three things: a control register, one data register that holds both the byte to send and the byte received, and a sticky completion flag with an optional interrupt. The serial side has a clock, two data lines and an active-low select. A control bit picks the role. Two more bits choose the clock polarity and phase, so all four SPI modes are supported. In master mode two further bits choose the bit rate.

In master mode, writing the data register starts a burst of eight clock periods. The byte goes out MSB first, and eight bits come back at the same time. In slave mode, the byte waiting in the data register is captured when select falls. It is then shifted out on the external clock while the incoming byte is assembled. The received byte reaches the data register only once the byte is complete. With phase 1 that is the eighth received clock. With phase 0 it is the moment select goes high again. The external clock, the slave-side MOSI and the select input are each resynchronised through two flops, and their edges are found in the system clock domain.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the control register reads 0, the data register reads 0, the completion flag and the interrupt are 0, and the serial clock output is 0.
- R2: In master mode (control bit 0 = 1), writing the data register produces exactly 16 serial clock transitions. MOSI carries the written byte MSB first, MISO is sampled once per period, and at the end the sampled byte appears in the data register and the completion flag is set.
- R3: Control bits [4:3] set the master clock period to 2, 4, 8 or 16 system clocks for codes 00, 01, 10 and 11. Every half period therefore lasts 1, 2, 4 or 8 system clocks.
- R4: Control bit 1 (polarity) is the idle level of the serial clock output before and after a master burst.
- R5: With control bit 2 (phase) = 0, the master puts the first bit on MOSI before the first clock edge and samples on the first edge of each period. With phase = 1, data changes on the first edge and is sampled on the second.
- R6: In master mode the select input has no effect on a transfer.
- R7: A data register write during a master burst is ignored. It neither changes the data register nor restarts the burst.
- R8: The completion flag stays set until a flag write of 0; a flag write of 1 has no effect. The interrupt equals the flag ANDed with control bit 5.
- R9: In slave mode the byte held in the data register when select falls goes out on MISO MSB first, and MOSI is shifted in. MISO is driven only while select is low. With phase = 1 the received byte is stored and the flag set after the eighth clock.
- R10: In slave mode with phase = 0, the data register and flag keep their values through all eight clocks. They update only when select rises.
- R11: In slave mode, if select rises before eight bits have arrived, the data register and flag are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write value: [0] master, [1] polarity, [2] phase, [4:3] rate, [5] interrupt enable |
| ctl_q | output | 6 | Control register contents |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | DW | Data register write value |
| dat_q | output | DW | Data register contents |
| flag_we | input | 1 | Completion flag write strobe |
| flag_wdata | input | 1 | Flag write value (0 clears) |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI as seen in slave mode |
| mosi_o | output | 1 | MOSI driven in master mode |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO as seen in master mode |
| miso_o | output | 1 | MISO driven in slave mode |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Master bursts are run over every combination of polarity, phase and rate. Random bytes are used in both directions, so a swapped bit order, a wrong sample edge or a wrong divider shows up as a corrupted byte or as uneven gaps between clock edges. While each burst runs, the bench toggles select at random and issues one stray data write, which separates a correct design from one that reacts to either. Slave transfers in all four modes check that the receive data is held back until the right point for the phase. Truncated slave transfers check that an incomplete byte is discarded.

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [5:0]    ctl_wdata,
  output logic [5:0]    ctl_q,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_q,
  input  logic          flag_we,
  input  logic          flag_wdata,
  output logic          done_flag,
  output logic          irq,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  localparam int EW = $clog2(2*DW);
  localparam int BW = $clog2(DW+1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW-1);

  logic c_master, c_cpol, c_cpha, c_ie;
  assign c_master = ctl_q[0];
  assign c_cpol   = ctl_q[1];
  assign c_cpha   = ctl_q[2];
  assign c_ie     = ctl_q[5];

  // master state
  logic          busy, sclk_q, mosi_q;
  logic [2:0]    half_cnt, lim;
  logic [EW-1:0] edge_cnt;
  logic [DW-1:0] m_tx, m_rx;

  // slave state
  logic [1:0]    sclk_sy, mosi_sy, ss_sy;
  logic          sclk_d, ss_d, miso_q;
  logic [BW-1:0] s_bits;
  logic [DW-1:0] s_tx, s_rx;

  always_comb begin
    case (ctl_q[4:3])
      2'd0:    lim = 3'd0;
      2'd1:    lim = 3'd1;
      2'd2:    lim = 3'd3;
      default: lim = 3'd7;
    endcase
  end

  logic m_start, m_edge, m_lead, m_samp, m_shft, m_done;
  logic [DW-1:0] m_rx_next, m_rx_fin;
  assign m_start   = dat_we && !busy && c_master;
  assign m_edge    = busy && (half_cnt == lim);
  assign m_lead    = ~edge_cnt[0];
  assign m_samp    = m_edge && (m_lead ^ c_cpha);
  assign m_shft    = m_edge && !(m_lead ^ c_cpha);
  assign m_done    = m_edge && (edge_cnt == LAST_EDGE);
  assign m_rx_next = {m_rx[DW-2:0], miso_i};
  assign m_rx_fin  = m_samp ? m_rx_next : m_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      half_cnt <= '0;
      edge_cnt <= '0;
      m_tx     <= '0;
      m_rx     <= '0;
    end else if (m_start) begin
      busy     <= 1'b1;
      sclk_q   <= c_cpol;
      half_cnt <= '0;
      edge_cnt <= '0;
      m_tx     <= dat_wdata;
      m_rx     <= '0;
    end else if (busy) begin
      half_cnt <= m_edge ? 3'd0 : half_cnt + 3'd1;
      if (m_edge) begin
        sclk_q   <= ~sclk_q;
        edge_cnt <= edge_cnt + EW'(1);
      end
      if (m_samp) m_rx <= m_rx_next;
      if (m_shft) begin
        if (c_cpha) mosi_q <= m_tx[DW-1];
        m_tx <= {m_tx[DW-2:0], 1'b0};
      end
      if (m_done) busy <= 1'b0;
    end
  end

  assign sclk_o  = busy ? sclk_q : c_cpol;
  assign sclk_oe = c_master;
  assign mosi_o  = c_cpha ? mosi_q : m_tx[DW-1];
  assign mosi_oe = c_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= 2'b00;
      mosi_sy <= 2'b00;
      ss_sy   <= 2'b11;
      sclk_d  <= 1'b0;
      ss_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      sclk_d  <= sclk_sy[1];
      ss_d    <= ss_sy[1];
    end
  end

  logic s_act, s_rise, s_fall, s_lead, s_trail, s_samp, s_shft, ss_fall, ss_rise, s_done;
  logic [DW-1:0] s_rx_next, s_rx_fin;
  assign s_act     = !c_master && !ss_sy[1];
  assign s_rise    = sclk_sy[1] && !sclk_d;
  assign s_fall    = !sclk_sy[1] && sclk_d;
  assign s_lead    = s_act && (c_cpol ? s_fall : s_rise);
  assign s_trail   = s_act && (c_cpol ? s_rise : s_fall);
  assign s_samp    = (c_cpha ? s_trail : s_lead) && (s_bits != BW'(DW));
  assign s_shft    = c_cpha ? s_lead : s_trail;
  assign ss_fall   = !c_master && !ss_sy[1] && ss_d;
  assign ss_rise   = !c_master && ss_sy[1] && !ss_d;
  assign s_rx_next = {s_rx[DW-2:0], mosi_sy[1]};
  assign s_done    = c_cpha ? (s_samp && s_bits == BW'(DW-1))
                            : (ss_rise && s_bits == BW'(DW));
  assign s_rx_fin  = c_cpha ? s_rx_next : s_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_tx   <= '0;
      s_rx   <= '0;
      s_bits <= '0;
      miso_q <= 1'b0;
    end else if (ss_fall) begin
      s_tx   <= dat_q;
      s_bits <= '0;
    end else begin
      if (s_samp) begin
        s_rx   <= s_rx_next;
        s_bits <= s_bits + BW'(1);
      end
      if (s_shft) begin
        if (c_cpha) miso_q <= s_tx[DW-1];
        s_tx <= {s_tx[DW-2:0], 1'b0};
      end
    end
  end

  assign miso_o  = c_cpha ? miso_q : s_tx[DW-1];
  assign miso_oe = s_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      dat_q     <= '0;
      done_flag <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (m_done)                 dat_q <= m_rx_fin;
      else if (s_done)            dat_q <= s_rx_fin;
      else if (dat_we && !busy)   dat_q <= dat_wdata;
      if (m_done || s_done)            done_flag <= 1'b1;
      else if (flag_we && !flag_wdata) done_flag <= 1'b0;
    end
  end

  assign irq = done_flag && c_ie;

  logic          chk_prev;
  logic [EW:0]   chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_prev <= 1'b0;
      chk_cnt  <= '0;
    end else begin
      chk_prev <= sclk_o;
      if (!busy)                  chk_cnt <= '0;
      else if (sclk_o != chk_prev) chk_cnt <= chk_cnt + (EW+1)'(1);
    end
  end

  AST_EIGHT_CLOCK_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_cnt + (EW+1)'(sclk_o != chk_prev)) == (EW+1)'(2*DW)); // R2

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dat_we && !m_done) |=> dat_q == $past(dat_q)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(flag_we && !flag_wdata)) |=> done_flag); // R8

  AST_NO_EARLY_SLAVE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_master && !c_cpha && !busy && !ss_sy[1] && !dat_we) |=> $stable(dat_q)); // R10
endmodule

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctl_we = 0, dat_we = 0, flag_we = 0, flag_wdata = 0;
  logic [5:0] ctl_wdata = '0, ctl_q;
  logic [7:0] dat_wdata = '0, dat_q;
  logic       done_flag, irq;
  logic       sclk_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  int         n_vec = 0, n_bad = 0;

  spi_byte_port #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_q(dat_q),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .done_flag(done_flag), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i)
  );

  always #5 clk = ~clk;

  function automatic int half_of(input logic [1:0] rate);
    return 1 << rate;
  endfunction

  function automatic logic [5:0] ctl_word(input bit m, cpol, cpha, input logic [1:0] rate, input bit ie);
    return {ie, rate, cpha, cpol, m};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_ctl(input logic [5:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic put_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1; dat_wdata = v;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic put_flag(input bit v);
    @(negedge clk); flag_we = 1; flag_wdata = v;
    @(negedge clk); flag_we = 0;
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] rx, input bit cpol, input bit cpha,
                            input logic [1:0] rate, input bit ie);
    int hp = half_of(rate);
    int edges = 0, since = 0, bad_gap = 0, drv;
    logic [7:0] cap = '0;
    bit prev, lead, junk = 0;
    put_ctl(ctl_word(1, cpol, cpha, rate, ie));
    put_flag(0);
    check("R4 idle level before burst", sclk_o, cpol);
    miso_i = rx[7];
    drv = cpha ? 0 : 1;
    @(negedge clk); dat_we = 1; dat_wdata = tx;
    @(negedge clk); dat_we = 0;
    check("R5 clock still idle after start", sclk_o, cpol);
    if (!cpha) check("R5 first bit ahead of first edge", mosi_o, tx[7]);
    prev = cpol;
    while (edges < 16 && since < 40) begin
      @(negedge clk);
      since++;
      dat_we = 0;
      ss_n_i = 1'($urandom);
      if (edges == 4 && !junk) begin dat_we = 1; dat_wdata = ~tx; junk = 1; end
      if (sclk_o != prev) begin
        edges++;
        prev = sclk_o;
        if (since != hp) bad_gap++;
        since = 0;
        lead = edges[0];
        if (lead ^ cpha) cap = {cap[6:0], mosi_o};
        else if (drv < 8) begin miso_i = rx[7-drv]; drv++; end
      end
    end
    dat_we = 0;
    ss_n_i = 1;
    check("R2 sixteen clock transitions", edges, 16);
    check("R3 half period length", bad_gap, 0);
    check("R2 R5 MOSI byte MSB first", cap, tx);
    check("R2 R6 R7 received byte", dat_q, rx);
    check("R2 flag set", done_flag, 1);
    check("R8 irq follows enable", irq, ie);
    check("R4 idle level after burst", sclk_o, cpol);
    tick(20);
    check("R7 no restart after stray write", {sclk_o, dat_q}, {cpol, rx});
  endtask

  task automatic run_slave(input logic [7:0] txs, input logic [7:0] rxm, input bit cpol, input bit cpha,
                           input int nb);
    logic [7:0] got = '0;
    put_ctl(ctl_word(0, cpol, cpha, 2'b00, 0));
    sclk_i = cpol; ss_n_i = 1; mosi_i = 0;
    put_flag(0);
    put_dat(txs);
    tick(4);
    check("R9 MISO released when deselected", miso_oe, 0);
    ss_n_i = 0;
    tick(8);
    check("R9 MISO driven when selected", miso_oe, 1);
    for (int i = 0; i < nb; i++) begin
      if (!cpha) begin
        mosi_i = rxm[7-i]; tick(8);
        got[7-i] = miso_o; sclk_i = ~cpol; tick(8);
        sclk_i = cpol;
      end else begin
        sclk_i = ~cpol; mosi_i = rxm[7-i]; tick(8);
        got[7-i] = miso_o; sclk_i = cpol; tick(8);
      end
    end
    tick(8);
    if (nb == 8) begin
      check("R9 MISO byte MSB first", got, txs);
      if (cpha) begin
        check("R9 stored at eighth clock", dat_q, rxm);
        check("R9 flag at eighth clock", done_flag, 1);
      end else begin
        check("R10 data held while selected", dat_q, txs);
        check("R10 flag held while selected", done_flag, 0);
        ss_n_i = 1; tick(6);
        check("R10 stored on select rise", dat_q, rxm);
        check("R10 flag on select rise", done_flag, 1);
      end
    end else begin
      ss_n_i = 1; tick(6);
      check("R11 short byte discarded", {done_flag, dat_q}, {1'b0, txs});
    end
    ss_n_i = 1;
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E));
    tick(3);
    rst_n = 1;
    tick(2);
    check("R1 control reset", ctl_q, 0);
    check("R1 data reset", dat_q, 0);
    check("R1 flag reset", done_flag, 0);
    check("R1 irq reset", irq, 0);
    check("R1 clock reset", sclk_o, 0);

    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++)
        run_master(8'($urandom), 8'($urandom), m[1], m[0], 2'(r), 1);
    run_master(8'h80, 8'h01, 0, 0, 2'd0, 1);
    run_master(8'h01, 8'h80, 1, 1, 2'd3, 0);
    for (int k = 0; k < 30; k++)
      run_master(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));

    for (int m = 0; m < 4; m++) begin
      run_slave(8'($urandom), 8'($urandom), m[1], m[0], 8);
      run_slave(8'($urandom), 8'($urandom), m[0], m[1], 3 + m);
    end
    for (int k = 0; k < 12; k++)
      run_slave(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 8);

    run_master(8'h5A, 8'hC3, 0, 1, 2'd1, 0);
    check("R8 irq masked", irq, 0);
    put_flag(1);
    check("R8 write of 1 keeps flag", done_flag, 1);
    put_ctl(ctl_word(1, 0, 1, 2'd1, 1));
    check("R8 irq with enable", irq, 1);
    put_flag(0);
    check("R8 write of 0 clears flag", {done_flag, irq}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule